// File: doc/BRIEF.md
# Buffered SPI Slave Port

This block is the slave end of a serial peripheral link. An external master drives the serial clock, an active-low select and the master-out data line; the block returns data on the master-in line. All three serial inputs are resampled by the system clock, and edges are found in the system clock domain. A word of 8 to 16 bits moves in each direction for every group of clock edges while the select line is low. The bit count, the idle level of the serial clock, and which clock edge captures data are all set by configuration inputs.

On the host side there is one holding register for outgoing data, one register for received data, and four flags: receive ready, transmit empty, overrun and underrun. A single shift register both sends and receives, so its content after a word is the received word. If the host has queued nothing new by the next word boundary, that received word goes back out and the underrun flag rises. When the shift register has no pending host data, a write made while the select is idle goes straight into it. Any later write replaces the content of the holding register, so the most recent value is the one that gets sent.

Top module: `spi_slave_buf`

## Requirements
- R1: While the synchronized select is high, serial clock edges have no effect: no bit is counted, no word completes and receive ready does not rise.
- R2: The effective word length is `cfg_len_i` clamped to the range 8..16. Words are sent and received most significant bit first.
- R3: `cfg_cpol_i` gives the idle level of the serial clock. With `cfg_ncpha_i`=1, data is captured on the edge that leaves the idle level. With `cfg_ncpha_i`=0, data is captured on the edge that returns to it. MISO changes only after a capture edge.
- R4: When the last bit of a word is captured, the received word is written right-justified (upper bits zero) to `rdr_data_o` and `rx_ready_o` goes to 1. A pulse on `rdr_rd_i` clears `rx_ready_o`.
- R5: A word that completes while `rx_ready_o` is 1 sets `overrun_o` and still replaces `rdr_data_o`. Only a pulse on `sr_rd_i` clears `overrun_o`.
- R6: After reset the shift register holds zero, so a first transfer with no host write sends all zeros.
- R7: A write while the select is idle, with no data pending in the shift register and an empty holding register, loads the shift register directly and leaves `tx_empty_o` at 1.
- R8: Any other write goes to the holding register, overwriting its content, and drops `tx_empty_o`. The held word moves into the shift register when the select falls or at the next word boundary, whichever comes first, and `tx_empty_o` then returns to 1.
- R9: At a word boundary with an empty holding register, the shift register keeps the received word, so it is sent again, and `underrun_o` is set. Only a pulse on `sr_rd_i` clears it.
- R10: If the select rises partway through a word, the bit counter is cleared, the partial word is discarded without touching `rdr_data_o` or `rx_ready_o`, and the next transfer starts on a word boundary.
- R11: `spi_miso_oe_o` is 1 only while the synchronized select is low. When it is 0, the pad should be high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from the master |
| spi_csn_i | input | 1 | Active-low select from the master |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| spi_miso_oe_o | output | 1 | Output enable for the MISO pad |
| cfg_len_i | input | LEN_W (5) | Requested word length in bits |
| cfg_cpol_i | input | 1 | Idle level of the serial clock |
| cfg_ncpha_i | input | 1 | 1: capture on the leading edge, 0: capture on the trailing edge |
| tdr_wr_i | input | 1 | Write strobe for transmit data |
| tdr_wdata_i | input | MAX_BITS (16) | Transmit data, right-justified |
| rdr_rd_i | input | 1 | Read strobe for receive data, clears receive ready |
| sr_rd_i | input | 1 | Status read strobe, clears overrun and underrun |
| rdr_data_o | output | MAX_BITS (16) | Last received word, right-justified |
| rx_ready_o | output | 1 | A received word is waiting |
| tx_empty_o | output | 1 | The holding register is free |
| overrun_o | output | 1 | A received word was overwritten before it was read |
| underrun_o | output | 1 | A word was re-sent because nothing was queued |

## Verification
The bound checker watches the flag protocol on every cycle. Receive ready, overrun and underrun must stay set until their clearing strobe arrives. Overrun may rise only while a word is still waiting. Transmit empty may fall only after a write and may rise only when no write is in progress. The output enable and receive ready must stay quiet once the select has been high for longer than the synchronizer delay. Whether the right bits come out, and in which order, can only be shown by the bench's scenarios: MISO content under both polarities and both phases, clamping of the word length, direct loading against held loading, re-sending of the received word, and recovery after an aborted word.

// File: rtl/spis_pkg.sv
package spis_pkg;

   typedef struct packed {
      logic cpol;
      logic ncpha;
   } spis_mode_t;

   typedef struct packed {
      logic ready;
      logic overrun;
      logic underrun;
   } spis_flags_t;

   // clamp a requested length into [lo, hi]
   function automatic int unsigned spis_clamp(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int                 WIDTH   = 3,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   initial begin
      if (STAGES < 2) $fatal(1, "spis_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $fatal(1, "spis_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
         else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end

      assign q_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/spis_edge.sv
module spis_edge
   import spis_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sclk_s_i,
   input  logic       csn_s_i,
   input  spis_mode_t mode_i,
   output logic       capture_o,
   output logic       sel_fall_o,
   output logic       sel_rise_o,
   output logic       active_o
);

   logic sclk_q;
   logic csn_q;
   logic up_edge;
   logic dn_edge;
   logic lead_edge;
   logic trail_edge;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
      end else begin
         sclk_q <= sclk_s_i;
         csn_q  <= csn_s_i;
      end
   end

   assign up_edge    = sclk_s_i & ~sclk_q;
   assign dn_edge    = ~sclk_s_i & sclk_q;
   assign lead_edge  = mode_i.cpol ? dn_edge : up_edge;
   assign trail_edge = mode_i.cpol ? up_edge : dn_edge;

   assign active_o   = ~csn_s_i;
   assign capture_o  = active_o & (mode_i.ncpha ? lead_edge : trail_edge);
   assign sel_fall_o = ~csn_s_i & csn_q;
   assign sel_rise_o = csn_s_i & ~csn_q;

endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
   parameter int MAX_BITS = 16,
   parameter int LEN_W    = 5
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                capture_i,
   input  logic                sel_fall_i,
   input  logic                sel_rise_i,
   input  logic                active_i,
   input  logic                mosi_s_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic                wr_i,
   input  logic [MAX_BITS-1:0] wdata_i,
   output logic                miso_o,
   output logic                done_o,
   output logic [MAX_BITS-1:0] rx_word_o,
   output logic                starve_o,
   output logic                tx_empty_o
);

   logic [MAX_BITS-1:0] sh_q;
   logic [MAX_BITS-1:0] hold_q;
   logic                hold_full_q;
   logic                loaded_q;
   logic [LEN_W-1:0]    cnt_q;
   logic [MAX_BITS-1:0] sh_next;
   logic [MAX_BITS-1:0] len_mask;
   logic                last_bit;

   assign sh_next  = {sh_q[MAX_BITS-2:0], mosi_s_i};
   assign last_bit = capture_i && (cnt_q == len_i - 1'b1);

   always_comb begin
      len_mask = '0;
      miso_o   = 1'b0;
      for (int i = 0; i < MAX_BITS; i++) begin
         len_mask[i] = (i < int'(len_i));
         if (i == int'(len_i) - 1) miso_o = sh_q[i];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q        <= '0;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         loaded_q    <= 1'b0;
         cnt_q       <= '0;
      end else begin
         if (sel_rise_i) begin
            cnt_q <= '0;
            if (cnt_q != '0) loaded_q <= 1'b0;
         end else if (capture_i) begin
            if (last_bit) begin
               cnt_q <= '0;
               if (hold_full_q) begin
                  sh_q        <= hold_q;
                  hold_full_q <= 1'b0;
                  loaded_q    <= 1'b1;
               end else begin
                  sh_q     <= sh_next;
                  loaded_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
               sh_q  <= sh_next;
            end
         end else if (sel_fall_i && hold_full_q) begin
            sh_q        <= hold_q;
            hold_full_q <= 1'b0;
            loaded_q    <= 1'b1;
         end

         if (wr_i) begin
            if (!active_i && !loaded_q && !hold_full_q) begin
               sh_q     <= wdata_i;
               loaded_q <= 1'b1;
            end else begin
               hold_q      <= wdata_i;
               hold_full_q <= 1'b1;
            end
         end
      end
   end

   assign done_o     = last_bit;
   assign rx_word_o  = sh_next & len_mask;
   assign starve_o   = last_bit && !hold_full_q;
   assign tx_empty_o = ~hold_full_q;

endmodule

// File: rtl/spis_status.sv
module spis_status
   import spis_pkg::*;
#(
   parameter int MAX_BITS = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                done_i,
   input  logic [MAX_BITS-1:0] rx_word_i,
   input  logic                starve_i,
   input  logic                rdr_rd_i,
   input  logic                sr_rd_i,
   output logic [MAX_BITS-1:0] rdata_o,
   output spis_flags_t         flags_o
);

   logic [MAX_BITS-1:0] rdr_q;
   spis_flags_t         fl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdr_q <= '0;
         fl_q  <= '0;
      end else begin
         if (sr_rd_i) begin
            fl_q.overrun  <= 1'b0;
            fl_q.underrun <= 1'b0;
         end
         if (done_i) begin
            rdr_q      <= rx_word_i;
            fl_q.ready <= 1'b1;
            if (fl_q.ready && !rdr_rd_i) fl_q.overrun <= 1'b1;
         end else if (rdr_rd_i) begin
            fl_q.ready <= 1'b0;
         end
         if (starve_i) fl_q.underrun <= 1'b1;
      end
   end

   assign rdata_o = rdr_q;
   assign flags_o = fl_q;

endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
   import spis_pkg::*;
#(
   parameter int  MAX_BITS    = 16,
   parameter int  MIN_BITS    = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int LEN_W       = $clog2(MAX_BITS + 1)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                spi_sclk_i,
   input  logic                spi_csn_i,
   input  logic                spi_mosi_i,
   output logic                spi_miso_o,
   output logic                spi_miso_oe_o,
   input  logic [LEN_W-1:0]    cfg_len_i,
   input  logic                cfg_cpol_i,
   input  logic                cfg_ncpha_i,
   input  logic                tdr_wr_i,
   input  logic [MAX_BITS-1:0] tdr_wdata_i,
   input  logic                rdr_rd_i,
   input  logic                sr_rd_i,
   output logic [MAX_BITS-1:0] rdr_data_o,
   output logic                rx_ready_o,
   output logic                tx_empty_o,
   output logic                overrun_o,
   output logic                underrun_o
);

   initial begin
      if (MIN_BITS < 2)         $fatal(1, "spi_slave_buf: MIN_BITS below 2");
      if (MAX_BITS < MIN_BITS)  $fatal(1, "spi_slave_buf: MAX_BITS below MIN_BITS");
      if (SYNC_STAGES < 2)      $fatal(1, "spi_slave_buf: SYNC_STAGES below 2");
   end

   localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(spis_clamp(MIN_BITS, 2, MAX_BITS));
   localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_BITS);

   logic [2:0]       pins_s;
   logic             csn_s;
   logic             sclk_s;
   logic             mosi_s;
   spis_mode_t       mode;
   logic             capture;
   logic             sel_fall;
   logic             sel_rise;
   logic             active;
   logic [LEN_W-1:0] len_eff;
   logic             done;
   logic             starve;
   logic             miso_bit;
   logic [MAX_BITS-1:0] rx_word;
   spis_flags_t      flags;

   spis_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({spi_csn_i, spi_sclk_i, spi_mosi_i}),
      .q_o    (pins_s)
   );

   assign csn_s  = pins_s[2];
   assign sclk_s = pins_s[1];
   assign mosi_s = pins_s[0];

   assign mode.cpol  = cfg_cpol_i;
   assign mode.ncpha = cfg_ncpha_i;

   always_comb begin
      if (cfg_len_i < LEN_LO)      len_eff = LEN_LO;
      else if (cfg_len_i > LEN_HI) len_eff = LEN_HI;
      else                         len_eff = cfg_len_i;
   end

   spis_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sclk_s_i   (sclk_s),
      .csn_s_i    (csn_s),
      .mode_i     (mode),
      .capture_o  (capture),
      .sel_fall_o (sel_fall),
      .sel_rise_o (sel_rise),
      .active_o   (active)
   );

   spis_shift #(
      .MAX_BITS (MAX_BITS),
      .LEN_W    (LEN_W)
   ) u_shift (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .capture_i  (capture),
      .sel_fall_i (sel_fall),
      .sel_rise_i (sel_rise),
      .active_i   (active),
      .mosi_s_i   (mosi_s),
      .len_i      (len_eff),
      .wr_i       (tdr_wr_i),
      .wdata_i    (tdr_wdata_i),
      .miso_o     (miso_bit),
      .done_o     (done),
      .rx_word_o  (rx_word),
      .starve_o   (starve),
      .tx_empty_o (tx_empty_o)
   );

   spis_status #(
      .MAX_BITS (MAX_BITS)
   ) u_status (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .done_i    (done),
      .rx_word_i (rx_word),
      .starve_i  (starve),
      .rdr_rd_i  (rdr_rd_i),
      .sr_rd_i   (sr_rd_i),
      .rdata_o   (rdr_data_o),
      .flags_o   (flags)
   );

   assign spi_miso_o    = active & miso_bit;
   assign spi_miso_oe_o = active;
   assign rx_ready_o    = flags.ready;
   assign overrun_o     = flags.overrun;
   assign underrun_o    = flags.underrun;

endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk_i,
   input logic rst_ni,
   input logic spi_csn_i,
   input logic spi_miso_oe_o,
   input logic tdr_wr_i,
   input logic rdr_rd_i,
   input logic sr_rd_i,
   input logic rx_ready_o,
   input logic tx_empty_o,
   input logic overrun_o,
   input logic underrun_o
);

   localparam int IDLE_LIM = SYNC_STAGES + 4;

   int unsigned idle_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    idle_cnt <= 0;
      else if (!spi_csn_i)            idle_cnt <= 0;
      else if (idle_cnt < IDLE_LIM)   idle_cnt <= idle_cnt + 1;
   end

   AST_READY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_ready_o && !rdr_rd_i |=> rx_ready_o); // R4

   AST_OVERRUN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_o && !sr_rd_i |=> overrun_o); // R5

   AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overrun_o) |-> $past(rx_ready_o)); // R5

   AST_UNDERRUN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_o && !sr_rd_i |=> underrun_o); // R9

   AST_TXE_FALL_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(tx_empty_o) |-> $past(tdr_wr_i)); // R8

   AST_TXE_RISE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_empty_o) |-> !$past(tdr_wr_i)); // R8

   AST_NO_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle_cnt > SYNC_STAGES) |-> !spi_miso_oe_o); // R11

   AST_NO_RX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle_cnt > SYNC_STAGES + 2) |-> !$rose(rx_ready_o)); // R1

endmodule

bind spi_slave_buf spi_slave_buf_chk #(
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .spi_csn_i     (spi_csn_i),
   .spi_miso_oe_o (spi_miso_oe_o),
   .tdr_wr_i      (tdr_wr_i),
   .rdr_rd_i      (rdr_rd_i),
   .sr_rd_i       (sr_rd_i),
   .rx_ready_o    (rx_ready_o),
   .tx_empty_o    (tx_empty_o),
   .overrun_o     (overrun_o),
   .underrun_o    (underrun_o)
);

// File: tb/sim_spi_slave_buf.sv
module sim_spi_slave_buf;

   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        csn = 1'b1;
   logic        mosi = 1'b0;
   logic        miso;
   logic        miso_oe;
   logic [4:0]  cfg_len = 5'd8;
   logic        cpol = 1'b0;
   logic        ncpha = 1'b1;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic        rdr_rd = 1'b0;
   logic        sr_rd = 1'b0;
   logic [15:0] rdata;
   logic        rdy, txe, ovr, udr;

   int n_chk = 0;
   int n_bad = 0;

   // reference state
   logic [15:0] m_sh = '0, m_hold = '0, m_rdr = '0;
   logic        m_full = 0, m_loaded = 0, m_rdy = 0, m_ovr = 0, m_udr = 0;

   always #4 clk = ~clk;

   spi_slave_buf u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .spi_sclk_i(sclk), .spi_csn_i(csn), .spi_mosi_i(mosi),
      .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
      .cfg_len_i(cfg_len), .cfg_cpol_i(cpol), .cfg_ncpha_i(ncpha),
      .tdr_wr_i(wr), .tdr_wdata_i(wdata), .rdr_rd_i(rdr_rd), .sr_rd_i(sr_rd),
      .rdr_data_o(rdata), .rx_ready_o(rdy), .tx_empty_o(txe),
      .overrun_o(ovr), .underrun_o(udr)
   );

   function automatic int eff_len(input logic [4:0] req);
      if (req < 8)  return 8;
      if (req > 16) return 16;
      return int'(req);
   endfunction

   function automatic logic [15:0] len_mask(input int n);
      return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   task automatic host_write(input logic [15:0] w);
      @(negedge clk); wr = 1'b1; wdata = w;
      @(negedge clk); wr = 1'b0;
      if (!m_loaded && !m_full) begin m_sh = w; m_loaded = 1; end
      else begin m_hold = w; m_full = 1; end
   endtask

   task automatic read_rdr();
      @(negedge clk); rdr_rd = 1'b1;
      @(negedge clk); rdr_rd = 1'b0;
      m_rdy = 0;
   endtask

   task automatic read_sr();
      @(negedge clk); sr_rd = 1'b1;
      @(negedge clk); sr_rd = 1'b0;
      m_ovr = 0; m_udr = 0;
   endtask

   task automatic set_mode(input logic p, input logic n, input logic [4:0] l);
      @(negedge clk);
      cpol = p; ncpha = n; cfg_len = l; sclk = p;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   // one bit period; returns MISO seen at the capture edge
   task automatic bit_cycle(input logic mo, output logic mi);
      if (ncpha) begin
         mosi = mo; wait_h();
         mi = miso; sclk = ~cpol; wait_h();
         sclk = cpol;
      end else begin
         sclk = ~cpol; mosi = mo; wait_h();
         mi = miso; sclk = cpol; wait_h();
      end
   endtask

   task automatic sel_low();
      csn = 1'b0;
      if (m_full) begin m_sh = m_hold; m_full = 0; m_loaded = 1; end
      wait_h();
   endtask

   task automatic sel_high();
      wait_h(); csn = 1'b1; repeat (2*H) @(negedge clk);
   endtask

   task automatic xfer_word(input logic [15:0] mo, input string req);
      int          n;
      logic [15:0] got;
      logic [15:0] exp;
      logic        b;
      n   = eff_len(cfg_len);
      exp = m_sh & len_mask(n);
      got = '0;
      for (int i = n - 1; i >= 0; i--) begin
         bit_cycle(mo[i], b);
         got[i] = b;
         m_sh = {m_sh[14:0], mo[i]};
      end
      check(req, "miso word", 32'(got), 32'(exp));
      m_ovr = m_ovr | m_rdy;
      m_rdy = 1;
      m_rdr = mo & len_mask(n);
      if (m_full) begin m_sh = m_hold; m_full = 0; m_loaded = 1; end
      else begin m_udr = 1; m_loaded = 0; end
   endtask

   task automatic frame(input int nw, input logic [15:0] m0, input logic [15:0] m1,
                        input string req);
      sel_low();
      xfer_word(m0, req);
      if (nw > 1) xfer_word(m1, req);
      sel_high();
   endtask

   task automatic check_flags();
      check("R4", "rdr data", 32'(rdata), 32'(m_rdr));
      check("R4", "rx ready", 32'(rdy), 32'(m_rdy));
      check("R5", "overrun", 32'(ovr), 32'(m_ovr));
      check("R9", "underrun", 32'(udr), 32'(m_udr));
      check("R8", "tx empty", 32'(txe), 32'(!m_full));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (all requirements)");
      summary();
      $finish;
   end

   initial begin : stim
      process::self().srandom(32'h5eed);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // reset state
      check("R11", "oe after reset", 32'(miso_oe), 32'd0);
      check("R8", "tx empty after reset", 32'(txe), 32'd1);
      check("R4", "ready after reset", 32'(rdy), 32'd0);
      check("R4", "rdr after reset", 32'(rdata), 32'd0);

      // R6: nothing written, zeros go out; R9 underrun at word end
      set_mode(1'b0, 1'b1, 5'd8);
      sel_low();
      check("R11", "oe while selected", 32'(miso_oe), 32'd1);
      xfer_word(16'h00A5, "R6");
      sel_high();
      check("R11", "oe after deselect", 32'(miso_oe), 32'd0);
      check_flags();

      // R9: received word goes back out; R5 overrun without a read
      frame(1, 16'h005A, 16'h0, "R9");
      check_flags();
      check("R5", "overrun set", 32'(ovr), 32'd1);
      read_rdr();
      check("R5", "overrun kept by data read", 32'(ovr), 32'd1);
      read_sr();
      check("R5", "overrun cleared by status read", 32'(ovr), 32'd0);
      check("R9", "underrun cleared by status read", 32'(udr), 32'd0);

      // R7: direct load while idle
      host_write(16'h003C);
      check("R7", "tx empty after direct load", 32'(txe), 32'd1);
      frame(1, 16'h00C3, 16'h0, "R7");
      check_flags();
      read_rdr(); read_sr();

      // R8: latest held value wins, loaded at select fall
      set_mode(1'b1, 1'b0, 5'd12);
      host_write(16'h0111);
      host_write(16'h0222);
      host_write(16'h0333);
      check("R8", "tx empty while held", 32'(txe), 32'd0);
      frame(2, 16'h0ABC, 16'h0456, "R8");
      check_flags();
      read_rdr(); read_sr();

      // R1: clock edges while deselected are ignored
      for (int k = 0; k < 10; k++) begin
         mosi = 1'($urandom); sclk = ~sclk; wait_h();
      end
      sclk = cpol; repeat (4) @(negedge clk);
      check("R1", "ready after idle clocks", 32'(rdy), 32'd0);
      frame(1, 16'h0F0F, 16'h0, "R1");
      check_flags();

      // R10: abort after three bits
      read_rdr(); read_sr();
      set_mode(1'b0, 1'b0, 5'd10);
      sel_low();
      for (int k = 0; k < 3; k++) begin
         logic b;
         logic mo;
         mo = 1'(k & 1);
         bit_cycle(mo, b);
         m_sh = {m_sh[14:0], mo};
      end
      m_loaded = 0;
      sel_high();
      check("R10", "ready after abort", 32'(rdy), 32'd0);
      check("R10", "rdr after abort", 32'(rdata), 32'(m_rdr));
      host_write(16'h02AA);
      frame(1, 16'h0155, 16'h0, "R10");
      check_flags();

      // R2: clamping of the word length
      read_rdr(); read_sr();
      set_mode(1'b1, 1'b1, 5'd3);
      host_write(16'hFF81);
      frame(1, 16'hFF7E, 16'h0, "R2");
      check("R2", "short length clamps to 8", 32'(rdata), 32'h7E);
      set_mode(1'b0, 1'b1, 5'd20);
      host_write(16'hBEEF);
      frame(1, 16'hCAFE, 16'h0, "R2");
      check("R2", "long length clamps to 16", 32'(rdata), 32'hCAFE);
      check_flags();

      // R3: random modes, lengths, writes and reads
      for (int it = 0; it < 48; it++) begin
         int          nwr;
         logic [15:0] a;
         logic [15:0] b;
         set_mode(1'($urandom), 1'($urandom), 5'(8 + $urandom % 9));
         nwr = $urandom % 3;
         for (int k = 0; k < nwr; k++) host_write(16'($urandom));
         if ($urandom % 2 == 0) read_rdr();
         if ($urandom % 3 == 0) read_sr();
         a = 16'($urandom);
         b = 16'($urandom);
         frame(1 + int'($urandom % 2), a, b, "R3");
         check_flags();
      end

      summary();
      $finish;
   end

endmodule